// File: doc/BRIEF.md
# Shared Output Pin with Tone Generator

This block drives a single output pin that serves one of two roles. In general-purpose mode the pin shows a one-bit output latch that software updates through an output-write strobe. In tone mode the pin carries a 50% duty square wave. The wave's frequency is one of seven values, each made by dividing the system clock by a different amount. A four-bit configuration word, written through its own strobe, selects the role and the tone. The pad is modelled as a data bit plus an output enable.

A backup-mode input takes the pin to high impedance. The pin stays released after backup ends, and only the next output write or configuration write drives it again. While tone mode is active, output writes still update the latch, but they have no visible effect until the block returns to general-purpose mode. At that point the latch value appears on the pin.

Both strobes are plain single-cycle register writes. The block accepts them on every cycle and applies no back-pressure, so it has no valid/ready pairing. Reset is synchronous and active high.

Top module: `shared_beep_port`

## Requirements
- R1: After reset, the pin is driven (pin_oe=1) and low, general-purpose mode is selected, and the latch and the tone code are both 0.
- R2: A configuration write takes cfg_data[3] as the mode (0 = general-purpose output, 1 = tone) and cfg_data[2:0] as the tone code. The pin reflects the new setting in the cycle after the write edge.
- R3: In general-purpose mode an output write stores out_data in the latch. The pin shows the stored value from the cycle after the write edge.
- R4: In tone mode an output write updates only the latch and leaves the pin unchanged.
- R5: In tone mode with code k (1 to 7), the pin is a square wave with a half period of BASE_HALF*(k+1) clock cycles. It is low immediately after the configuration write and first rises BASE_HALF*(k+1) edges after the write edge.
- R6: In tone mode with code 000, the pin is held low.
- R7: A configuration write that changes the tone code restarts the divider with the pin low. A write that keeps the same code leaves the wave's phase undisturbed.
- R8: On a return from tone mode to general-purpose mode, the pin shows the current latch value in the cycle after the write. This includes any value written while tone mode was active.
- R9: With backup high at a clock edge, pin_oe is 0 from the next cycle. pin_o is 0 whenever pin_oe is 0.
- R10: After backup falls, the pin stays released until an output write or a configuration write occurs with backup low. A write in a cycle with backup high does not re-drive the pin.
- R11: A configuration write and an output write in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the source of the tone |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_data | input | 4 | Bit 3 mode, bits 2..0 tone code |
| out_wr | input | 1 | Output latch write strobe |
| out_data | input | 1 | Value for the output latch |
| backup | input | 1 | Backup mode; releases the pin |
| pin_o | output | 1 | Pin data |
| pin_oe | output | 1 | Pin output enable (0 = high impedance) |

## Verification
The bench builds the block with BASE_HALF=2, which gives half periods of 4 to 16 cycles. Several full periods of every one of the seven tones therefore fit in a short run, and each toggle edge can be checked exactly. With periods this short, the phase-continuity case for a repeated code and the restart case for a changed code both land within a few cycles of the write. The default BASE_HALF targets audible tones and is far too slow to cover fully.

// File: rtl/beep_port_pkg.sv
package beep_port_pkg;
  typedef enum logic {MODE_GPO = 1'b0, MODE_TONE = 1'b1} port_mode_e;
  typedef logic [2:0] tone_code_t;

  localparam int NUM_CODES = 8;

  // Half period in clocks for a tone code; code 0 is unused (silent)
  function automatic int tone_half(input int base, input int code);
    return base * (code + 1);
  endfunction
endpackage

// File: rtl/beep_cfg_regs.sv
module beep_cfg_regs
  import beep_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_wr,
  input  logic [3:0] cfg_data,
  input  logic       out_wr,
  input  logic       out_data,
  input  logic       backup,
  output port_mode_e mode_q,
  output tone_code_t code_q,
  output logic       latch_q,
  output logic       hiz_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_GPO;
      code_q  <= '0;
      latch_q <= 1'b0;
      hiz_q   <= 1'b0;
    end else begin
      if (cfg_wr) begin
        mode_q <= port_mode_e'(cfg_data[3]);
        code_q <= cfg_data[2:0];
      end
      if (out_wr) latch_q <= out_data;
      if (backup) hiz_q <= 1'b1;
      else if (cfg_wr || out_wr) hiz_q <= 1'b0;
    end
  end
endmodule

// File: rtl/beep_tone_div.sv
module beep_tone_div
  import beep_port_pkg::*;
#(
  parameter int BASE_HALF = 2000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       enable,
  input  logic       restart,
  input  tone_code_t code,
  output logic       tone
);
  localparam int MAX_HALF = tone_half(BASE_HALF, NUM_CODES - 1);
  localparam int CNT_W    = $clog2(MAX_HALF + 1);

  logic [CNT_W-1:0] last_tab [NUM_CODES];
  logic [CNT_W-1:0] cnt_q;
  logic             tone_q;

  for (genvar g = 0; g < NUM_CODES; g++) begin : g_tab
    assign last_tab[g] = CNT_W'(tone_half(BASE_HALF, g) - 1);
  end

  always_ff @(posedge clk) begin
    if (rst || restart || !enable) begin
      cnt_q  <= '0;
      tone_q <= 1'b0;
    end else if (cnt_q == last_tab[code]) begin
      cnt_q  <= '0;
      tone_q <= ~tone_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tone = tone_q;
endmodule

// File: rtl/shared_beep_port.sv
module shared_beep_port
  import beep_port_pkg::*;
#(
  parameter int BASE_HALF = 2000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_wr,
  input  logic [3:0] cfg_data,
  input  logic       out_wr,
  input  logic       out_data,
  input  logic       backup,
  output logic       pin_o,
  output logic       pin_oe
);
  port_mode_e mode_q;
  tone_code_t code_q;
  logic       latch_q;
  logic       hiz_q;
  logic       tone;
  logic       div_en;
  logic       div_restart;

  beep_cfg_regs u_regs (
    .clk      (clk),
    .rst      (rst),
    .cfg_wr   (cfg_wr),
    .cfg_data (cfg_data),
    .out_wr   (out_wr),
    .out_data (out_data),
    .backup   (backup),
    .mode_q   (mode_q),
    .code_q   (code_q),
    .latch_q  (latch_q),
    .hiz_q    (hiz_q)
  );

  assign div_en      = (mode_q == MODE_TONE) && (code_q != '0);
  assign div_restart = cfg_wr && (cfg_data[2:0] != code_q);

  beep_tone_div #(.BASE_HALF(BASE_HALF)) u_div (
    .clk     (clk),
    .rst     (rst),
    .enable  (div_en),
    .restart (div_restart),
    .code    (code_q),
    .tone    (tone)
  );

  always_comb begin
    if (hiz_q)                    pin_o = 1'b0;
    else if (mode_q == MODE_TONE) pin_o = tone;
    else                          pin_o = latch_q;
  end
  assign pin_oe = ~hiz_q;
endmodule

// File: rtl/shared_beep_port_chk.sv
module shared_beep_port_chk (
  input logic       clk,
  input logic       rst,
  input logic       cfg_wr,
  input logic       out_wr,
  input logic       out_data,
  input logic       backup,
  input logic       pin_o,
  input logic       pin_oe,
  input logic       mode_q,
  input logic [2:0] code_q
);
  // R9
  backup_release_chk: assert property (@(posedge clk) disable iff (rst)
    backup |=> !pin_oe);

  // R9
  hiz_low_chk: assert property (@(posedge clk) disable iff (rst)
    !pin_oe |-> !pin_o);

  // R10
  hiz_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!pin_oe && !cfg_wr && !out_wr) |=> !pin_oe);

  // R10
  redrive_chk: assert property (@(posedge clk) disable iff (rst)
    ((cfg_wr || out_wr) && !backup) |=> pin_oe);

  // R3
  gpo_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (out_wr && !cfg_wr && !backup && !mode_q) |=> (pin_o == $past(out_data)));

  // R6
  silent_code_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q && code_q == 3'd0) |-> !pin_o);
endmodule

bind shared_beep_port shared_beep_port_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .cfg_wr   (cfg_wr),
  .out_wr   (out_wr),
  .out_data (out_data),
  .backup   (backup),
  .pin_o    (pin_o),
  .pin_oe   (pin_oe),
  .mode_q   (mode_q),
  .code_q   (code_q)
);

// File: tb/shared_beep_port_bench.sv
`timescale 1ns/1ps
module shared_beep_port_bench;
  localparam int BASE = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_wr = 1'b0;
  logic [3:0] cfg_data = '0;
  logic       out_wr = 1'b0;
  logic       out_data = 1'b0;
  logic       backup = 1'b0;
  logic       pin_o;
  logic       pin_oe;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  shared_beep_port #(.BASE_HALF(BASE)) u_shared_beep_port (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
    .out_wr(out_wr), .out_data(out_data), .backup(backup),
    .pin_o(pin_o), .pin_oe(pin_oe)
  );

  // {latch value, config word}
  localparam logic [4:0] VEC [0:8] = '{
    5'b1_0000, 5'b0_1001, 5'b1_1010, 5'b0_1011, 5'b1_1100,
    5'b0_1101, 5'b1_1110, 5'b0_1111, 5'b1_1000
  };

  task automatic check(input string req, input logic got, input logic exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic do_cfg(input logic [3:0] d);
    @(negedge clk); cfg_wr = 1'b1; cfg_data = d;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic do_out(input logic d);
    @(negedge clk); out_wr = 1'b1; out_data = d;
    @(negedge clk); out_wr = 1'b0;
  endtask

  function automatic logic tone_at(input int code, input int n);
    int h = BASE * (code + 1);
    return ((n / h) % 2) == 1;
  endfunction

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 oe", pin_oe, 1'b1);
    check("R1 pin", pin_o, 1'b0);

    // Table walk: R2, R3, R5, R6
    for (int i = 0; i < 9; i++) begin
      logic [3:0] w;
      logic       lv;
      int         code;
      w = VEC[i][3:0];
      lv = VEC[i][4];
      code = int'(w[2:0]);
      do_cfg(4'b0000);
      do_out(lv);
      check("R3 latch shown", pin_o, lv);
      do_cfg(w);
      for (int n = 0; n < 4 * BASE * 8; n++) begin
        if (!w[3]) check("R2 gpo mode", pin_o, lv);
        else if (code == 0) check("R6 silent", pin_o, 1'b0);
        else check("R5 tone", pin_o, tone_at(code, n));
        @(negedge clk);
      end
    end

    // R4 / R8: latch write absorbed in tone mode, shown on return
    do_cfg(4'b0000);
    do_out(1'b0);
    do_cfg(4'b1000);
    do_out(1'b1);
    check("R4 absorbed", pin_o, 1'b0);
    do_cfg(4'b0000);
    check("R8 latch on return", pin_o, 1'b1);

    // R4 with a running tone: write mid-wave does not disturb phase
    do_cfg(4'b1001);              // code 1, half 4
    repeat (5) @(negedge clk);   // n = 5 -> high
    check("R5 mid", pin_o, 1'b1);
    @(negedge clk); out_wr = 1'b0; out_data = 1'b0; out_wr = 1'b1;
    @(negedge clk); out_wr = 1'b0; // n = 7
    check("R4 phase", pin_o, tone_at(1, 7));
    do_cfg(4'b0000);
    check("R8 latch 0", pin_o, 1'b0);

    // R7: same code keeps phase, changed code restarts
    do_cfg(4'b1010);              // half 6
    repeat (7) @(negedge clk);   // n = 7 -> high
    check("R7 pre", pin_o, 1'b1);
    do_cfg(4'b1010);              // n = 9
    check("R7 same code", pin_o, tone_at(2, 9));
    repeat (4) @(negedge clk);   // n = 13
    check("R7 continue", pin_o, tone_at(2, 13));
    do_cfg(4'b1011);              // restart, half 8
    check("R7 restart low", pin_o, 1'b0);
    repeat (8) @(negedge clk);
    check("R7 first rise", pin_o, 1'b1);

    // R9 / R10 backup
    @(negedge clk); backup = 1'b1;
    @(negedge clk);
    check("R9 oe", pin_oe, 1'b0);
    check("R9 pin", pin_o, 1'b0);
    out_wr = 1'b1; out_data = 1'b1;   // write during backup
    @(negedge clk); out_wr = 1'b0; backup = 1'b0;
    check("R10 write in backup", pin_oe, 1'b0);
    repeat (5) @(negedge clk);
    check("R10 hold", pin_oe, 1'b0);
    do_cfg(4'b0000);
    check("R10 release by cfg", pin_oe, 1'b1);
    check("R10 latch kept", pin_o, 1'b1);
    @(negedge clk); backup = 1'b1;
    @(negedge clk); backup = 1'b0;
    check("R9 oe again", pin_oe, 1'b0);
    do_out(1'b0);
    check("R10 release by out", pin_oe, 1'b1);
    check("R10 pin", pin_o, 1'b0);

    // R11 simultaneous writes
    do_cfg(4'b1000);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_data = 4'b0000; out_wr = 1'b1; out_data = 1'b1;
    @(negedge clk); cfg_wr = 1'b0; out_wr = 1'b0;
    check("R11 both", pin_o, 1'b1);

    // R1 reset again from a non-default state
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 reset pin", pin_o, 1'b0);
    check("R1 reset oe", pin_oe, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule